// File: doc/BRIEF.md
# Processor Halt and Wake Controller

This block holds the activity state of one processor core and decides, cycle by cycle, whether the core may run. The execution pipeline asks the block to put the core to sleep in one of four sleep states: plain halt, monitor-wait, interrupt-tolerant monitor-wait, or wait-for-startup. The block then watches the pending-event lines and returns the core to the active state as soon as a wake rule is met. In the cycle that the wake is seen, it raises run-enable and pulses the clear for the interrupt-inhibit shadow. When the core leaves a monitor-wait state, it also pulses a reset to the address monitor.

The block also keeps the mask bits for the non-maskable (NMI), system-management (SMI) and INIT events, and it latches a pending INIT. A startup request brings a core out of wait-for-startup and produces the code-segment value at which the core resumes, with the instruction pointer at zero. A startup request that comes in any other state is dropped and flagged.

Top module: `halt_wake_ctrl`

## Requirements
- R1: A synchronous active-high reset sets the following, visible in the cycle after reset: state 0 (active), all event masks clear, no pending INIT, start code segment 0, run-enable high.
- R2: While active, a sleep request with code 1 (halt), 2 (wait-for-startup), 3 (monitor-wait) or 4 (interrupt-tolerant monitor-wait) moves the state to that code on the next cycle. Codes 0 and 5 to 7 are ignored. While asleep and not waking, run-enable is low.
- R3: In states 1 and 3, a maskable or local interrupt wakes the core only when the interrupt-enable flag is 1.
- R4: In state 4, a maskable or local interrupt wakes the core even when the interrupt-enable flag is 0.
- R5: In states 1, 3 and 4, an NMI, an SMI or a pending INIT wakes the core whatever the interrupt-enable flag is, provided its mask bit is clear. A masked event does not wake the core.
- R6: Run-enable and the inhibit-clear pulse are high in the same cycle the wake condition is seen. The state reads 0 on the next cycle.
- R7: The monitor-reset pulse is high exactly on a wake taken from state 3 or 4.
- R8: In state 2, interrupts, NMI, SMI and INIT do not wake the core. Only a startup request does.
- R9: A startup request in state 2 wakes the core. On the next cycle the state is 0, the start code segment equals vector × 0x100, and the NMI, SMI and INIT masks are all clear.
- R10: A startup request in any state other than 2 raises the ignored flag in that cycle. It leaves the state and the start code segment unchanged.
- R11: An INIT request sets the pending INIT only if the INIT mask is clear. The pending INIT is cleared by any wake.
- R12: The mask-set input sets event mask bits: bit 0 is NMI, bit 1 is SMI, bit 2 is INIT. The event-mask output shows these bits in the same positions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| sleep_req_i | input | 1 | Request to enter the sleep state given by sleep_code_i |
| sleep_code_i | input | 3 | Requested state code (1..4 valid) |
| if_flag_i | input | 1 | Interrupt-enable flag |
| intr_i | input | 1 | Maskable interrupt pending |
| lintr_i | input | 1 | Local interrupt pending |
| nmi_i | input | 1 | NMI pending |
| smi_i | input | 1 | SMI pending |
| init_req_i | input | 1 | INIT delivery request |
| mask_set_i | input | 3 | Set mask bits (0 NMI, 1 SMI, 2 INIT) |
| sipi_req_i | input | 1 | Startup request |
| sipi_vec_i | input | VEC_W | Startup vector |
| state_o | output | 3 | Current state code |
| run_en_o | output | 1 | Core may execute |
| mon_rst_o | output | 1 | Address monitor reset pulse |
| clr_inhibit_o | output | 1 | Clear interrupt-inhibit shadow pulse |
| sipi_ignored_o | output | 1 | Startup request dropped |
| start_cs_o | output | VEC_W+CS_SHIFT | Code segment for restart |
| event_mask_o | output | 3 | Current event masks |
| init_pend_o | output | 1 | INIT pending |

## Verification
The bench builds the block with its default parameters: an 8-bit startup vector shifted by 8 bits into a 16-bit code segment. With these values, random vectors cover the full range 0 to 0xFF, and the directed cases 0xA5 and 0xFF check the top byte of the segment completely. Random stimulus drives every sleep code, including the illegal ones, against every mix of events and mask bits. This reaches the rarer cases: masked INIT arriving together with a wake, startup requests outside wait-for-startup, and a reset falling in the middle of a sleep.

// File: rtl/halt_wake_pkg.sv
`timescale 1ns/1ps
package halt_wake_pkg;

    typedef enum logic [2:0] {
        ST_ACTIVE     = 3'd0,
        ST_HALT       = 3'd1,
        ST_WAIT_START = 3'd2,
        ST_MWAIT      = 3'd3,
        ST_MWAIT_INTR = 3'd4
    } core_state_e;

    localparam int NUM_GATED = 3;
    localparam int EV_NMI    = 0;
    localparam int EV_SMI    = 1;
    localparam int EV_INIT   = 2;

    typedef struct packed {
        logic evt_wake;
        logic sipi_accept;
        logic sipi_ignored;
        logic mon_rst;
    } wake_decision_t;

    function automatic logic is_monitor_wait(core_state_e s);
        return (s == ST_MWAIT) || (s == ST_MWAIT_INTR);
    endfunction

    function automatic logic is_event_sleep(core_state_e s);
        return (s == ST_HALT) || is_monitor_wait(s);
    endfunction

    function automatic logic valid_sleep_code(logic [2:0] c);
        return (c >= 3'd1) && (c <= 3'd4);
    endfunction

    function automatic core_state_e decode_state(logic [2:0] c);
        core_state_e s;
        case (c)
            3'd1:    s = ST_HALT;
            3'd2:    s = ST_WAIT_START;
            3'd3:    s = ST_MWAIT;
            3'd4:    s = ST_MWAIT_INTR;
            default: s = ST_ACTIVE;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/hw_wake_eval.sv
`timescale 1ns/1ps
module hw_wake_eval
    import halt_wake_pkg::*;
#(
    parameter int NG = NUM_GATED
) (
    input  core_state_e        state,
    input  logic               if_flag,
    input  logic               intr,
    input  logic               lintr,
    input  logic [NG-1:0]      gated_src,
    input  logic [NG-1:0]      gated_mask,
    input  logic               sipi_req,
    output wake_decision_t     dec
);
    logic [NG-1:0] gated_hit;
    logic          irq_ok;

    for (genvar g = 0; g < NG; g++) begin : g_gate
        assign gated_hit[g] = gated_src[g] & ~gated_mask[g];
    end

    assign irq_ok = (intr | lintr) & (if_flag | (state == ST_MWAIT_INTR));

    always_comb begin
        dec.evt_wake     = is_event_sleep(state) & (irq_ok | (|gated_hit));
        dec.sipi_accept  = (state == ST_WAIT_START) & sipi_req;
        dec.sipi_ignored = (state != ST_WAIT_START) & sipi_req;
        dec.mon_rst      = dec.evt_wake & is_monitor_wait(state);
    end

    always_comb begin
        assert (!(dec.evt_wake && dec.sipi_accept))
            else $error("p_single_cause_r8: event and startup wake together");
    end

endmodule

// File: rtl/hw_event_gate.sv
`timescale 1ns/1ps
module hw_event_gate
    import halt_wake_pkg::*;
#(
    parameter int NG = NUM_GATED
) (
    input  logic          clk_i,
    input  logic          rst_i,
    input  logic [NG-1:0] mask_set,
    input  logic          unmask_all,
    input  logic          init_req,
    input  logic          consume,
    output logic [NG-1:0] mask_q,
    output logic          init_pend_q
);
    logic [NG-1:0] mask_d;
    logic          init_pend_d;

    always_comb begin
        mask_d = unmask_all ? '0 : (mask_q | mask_set);
        init_pend_d = (init_pend_q & ~consume) | (init_req & ~mask_q[EV_INIT]);
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            mask_q      <= '0;
            init_pend_q <= 1'b0;
        end else begin
            mask_q      <= mask_d;
            init_pend_q <= init_pend_d;
        end
    end

    p_init_drop_r11: assert property (@(posedge clk_i) disable iff (rst_i)
        (init_req && mask_q[EV_INIT] && !init_pend_q) |=> !init_pend_q);

    p_unmask_r9: assert property (@(posedge clk_i) disable iff (rst_i)
        unmask_all |=> (mask_q == '0));

    p_mask_sticky_r12: assert property (@(posedge clk_i) disable iff (rst_i)
        (!unmask_all) |=> ((mask_q & $past(mask_q)) == $past(mask_q)));

endmodule

// File: rtl/hw_start_capture.sv
`timescale 1ns/1ps
module hw_start_capture #(
    parameter int VEC_W    = 8,
    parameter int CS_SHIFT = 8,
    localparam int CS_W    = VEC_W + CS_SHIFT
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             load,
    input  logic [VEC_W-1:0] vec,
    output logic [CS_W-1:0]  cs_q
);
    always_ff @(posedge clk_i) begin
        if (rst_i)     cs_q <= '0;
        else if (load) cs_q <= {vec, {CS_SHIFT{1'b0}}};
    end

    p_cs_load_r9: assert property (@(posedge clk_i) disable iff (rst_i)
        load |=> (cs_q[CS_W-1:CS_SHIFT] == $past(vec)) && (cs_q[CS_SHIFT-1:0] == '0));

    p_cs_hold_r10: assert property (@(posedge clk_i) disable iff (rst_i)
        !load |=> $stable(cs_q));

endmodule

// File: rtl/halt_wake_ctrl.sv
`timescale 1ns/1ps
module halt_wake_ctrl
    import halt_wake_pkg::*;
#(
    parameter int VEC_W    = 8,
    parameter int CS_SHIFT = 8,
    localparam int CS_W    = VEC_W + CS_SHIFT
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             sleep_req_i,
    input  logic [2:0]       sleep_code_i,
    input  logic             if_flag_i,
    input  logic             intr_i,
    input  logic             lintr_i,
    input  logic             nmi_i,
    input  logic             smi_i,
    input  logic             init_req_i,
    input  logic [2:0]       mask_set_i,
    input  logic             sipi_req_i,
    input  logic [VEC_W-1:0] sipi_vec_i,
    output logic [2:0]       state_o,
    output logic             run_en_o,
    output logic             mon_rst_o,
    output logic             clr_inhibit_o,
    output logic             sipi_ignored_o,
    output logic [CS_W-1:0]  start_cs_o,
    output logic [2:0]       event_mask_o,
    output logic             init_pend_o
);
    core_state_e          state_q, state_d;
    wake_decision_t       dec;
    logic [NUM_GATED-1:0] gated_src;
    logic [NUM_GATED-1:0] mask_q;
    logic                 init_pend_q;
    logic                 any_wake;

    always_comb begin
        gated_src          = '0;
        gated_src[EV_NMI]  = nmi_i;
        gated_src[EV_SMI]  = smi_i;
        gated_src[EV_INIT] = init_pend_q;
    end

    hw_wake_eval #(.NG(NUM_GATED)) u_eval (
        .state      (state_q),
        .if_flag    (if_flag_i),
        .intr       (intr_i),
        .lintr      (lintr_i),
        .gated_src  (gated_src),
        .gated_mask (mask_q),
        .sipi_req   (sipi_req_i),
        .dec        (dec)
    );

    assign any_wake = dec.evt_wake | dec.sipi_accept;

    hw_event_gate #(.NG(NUM_GATED)) u_gate (
        .clk_i       (clk_i),
        .rst_i       (rst_i),
        .mask_set    (mask_set_i),
        .unmask_all  (dec.sipi_accept),
        .init_req    (init_req_i),
        .consume     (any_wake),
        .mask_q      (mask_q),
        .init_pend_q (init_pend_q)
    );

    hw_start_capture #(.VEC_W(VEC_W), .CS_SHIFT(CS_SHIFT)) u_cap (
        .clk_i (clk_i),
        .rst_i (rst_i),
        .load  (dec.sipi_accept),
        .vec   (sipi_vec_i),
        .cs_q  (start_cs_o)
    );

    always_comb begin
        state_d = state_q;
        if (any_wake)
            state_d = ST_ACTIVE;
        else if (state_q == ST_ACTIVE && sleep_req_i && valid_sleep_code(sleep_code_i))
            state_d = decode_state(sleep_code_i);
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) state_q <= ST_ACTIVE;
        else       state_q <= state_d;
    end

    assign state_o        = state_q;
    assign run_en_o       = (state_q == ST_ACTIVE) | any_wake;
    assign mon_rst_o      = dec.mon_rst;
    assign clr_inhibit_o  = any_wake;
    assign sipi_ignored_o = dec.sipi_ignored;
    assign event_mask_o   = mask_q;
    assign init_pend_o    = init_pend_q;

    p_reset_active_r1: assert property (@(posedge clk_i) disable iff (rst_i)
        $past(rst_i) |-> (state_o == 3'd0) && run_en_o);

    p_halt_ifoff_r3: assert property (@(posedge clk_i) disable iff (rst_i)
        (state_o == 3'd1 && !if_flag_i && !nmi_i && !smi_i && !init_pend_o && !sipi_req_i)
        |-> !run_en_o);

    p_mwaitif_r4: assert property (@(posedge clk_i) disable iff (rst_i)
        (state_o == 3'd4 && intr_i) |-> run_en_o && mon_rst_o);

    p_wake_active_r6: assert property (@(posedge clk_i) disable iff (rst_i)
        (state_o != 3'd0 && run_en_o) |=> (state_o == 3'd0));

    p_monrst_r7: assert property (@(posedge clk_i) disable iff (rst_i)
        mon_rst_o |-> clr_inhibit_o && (state_o >= 3'd3));

    p_wfs_hold_r8: assert property (@(posedge clk_i) disable iff (rst_i)
        (state_o == 3'd2 && !sipi_req_i) |=> (state_o == 3'd2));

    p_ignore_r10: assert property (@(posedge clk_i) disable iff (rst_i)
        sipi_ignored_o |=> $stable(start_cs_o));

endmodule

// File: tb/halt_wake_ctrl_tb_top.sv
`timescale 1ns/1ps
module halt_wake_ctrl_tb_top;

    logic        clk = 1'b0;
    logic        rst;
    logic        sleep_req;
    logic [2:0]  sleep_code;
    logic        if_flag, intr, lintr, nmi, smi, init_req;
    logic [2:0]  mask_set;
    logic        sipi_req;
    logic [7:0]  sipi_vec;
    logic [2:0]  state;
    logic        run_en, mon_rst, clr_inh, sipi_ign, init_pend;
    logic [15:0] start_cs;
    logic [2:0]  ev_mask;

    int n_tests = 0;
    int n_fail  = 0;

    int          m_state;
    logic [2:0]  m_mask;
    logic        m_ip;
    logic [15:0] m_cs;

    always #10 clk = ~clk;

    halt_wake_ctrl dut_i (
        .clk_i(clk), .rst_i(rst), .sleep_req_i(sleep_req), .sleep_code_i(sleep_code),
        .if_flag_i(if_flag), .intr_i(intr), .lintr_i(lintr), .nmi_i(nmi), .smi_i(smi),
        .init_req_i(init_req), .mask_set_i(mask_set), .sipi_req_i(sipi_req),
        .sipi_vec_i(sipi_vec), .state_o(state), .run_en_o(run_en), .mon_rst_o(mon_rst),
        .clr_inhibit_o(clr_inh), .sipi_ignored_o(sipi_ign), .start_cs_o(start_cs),
        .event_mask_o(ev_mask), .init_pend_o(init_pend)
    );

    task automatic check(input string req, input string what, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic logic f_evt();
        logic irq, gated;
        if (!(m_state == 1 || m_state == 3 || m_state == 4)) return 1'b0;
        irq   = (intr | lintr) & (if_flag | (m_state == 4));
        gated = (nmi & ~m_mask[0]) | (smi & ~m_mask[1]) | (m_ip & ~m_mask[2]);
        return irq | gated;
    endfunction

    function automatic logic f_acc();
        return (m_state == 2) && sipi_req;
    endfunction

    task automatic compare_all();
        logic evt, acc;
        evt = f_evt();
        acc = f_acc();
        check("R2",  "state",     state, m_state);
        check("R6",  "run_en",    run_en, (m_state == 0) || evt || acc);
        check("R6",  "clr_inh",   clr_inh, evt || acc);
        check("R7",  "mon_rst",   mon_rst, evt && (m_state >= 3));
        check("R10", "sipi_ign",  sipi_ign, sipi_req && (m_state != 2));
        check("R12", "ev_mask",   ev_mask, m_mask);
        check("R11", "init_pend", init_pend, m_ip);
        check("R9",  "start_cs",  start_cs, m_cs);
    endtask

    task automatic update_model();
        logic evt, acc, wk;
        if (rst) begin
            m_state = 0; m_mask = 3'b000; m_ip = 1'b0; m_cs = 16'h0;
            return;
        end
        evt = f_evt();
        acc = f_acc();
        wk  = evt | acc;
        m_ip = (m_ip & ~wk) | (init_req & ~m_mask[2]);
        if (acc) begin
            m_state = 0; m_mask = 3'b000; m_cs = {sipi_vec, 8'h00};
        end else begin
            m_mask = m_mask | mask_set;
            if (evt) m_state = 0;
            else if (m_state == 0 && sleep_req && sleep_code >= 1 && sleep_code <= 4)
                m_state = sleep_code;
        end
    endtask

    task automatic tick();
        #1;
        compare_all();
        @(posedge clk);
        update_model();
        @(negedge clk);
    endtask

    task automatic idle();
        rst = 0; sleep_req = 0; sleep_code = 0; if_flag = 0; intr = 0; lintr = 0;
        nmi = 0; smi = 0; init_req = 0; mask_set = 0; sipi_req = 0; sipi_vec = 0;
    endtask

    task automatic go_sleep(input logic [2:0] code);
        idle(); sleep_req = 1; sleep_code = code; tick(); idle();
    endtask

    initial begin
        #(20 * 200000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'h5eed1234));
        m_state = 0; m_mask = 0; m_ip = 0; m_cs = 0;
        idle(); rst = 1;
        @(negedge clk);
        tick(); tick();
        idle(); #1;
        check("R1", "reset state", state, 0);
        check("R1", "reset run_en", run_en, 1);
        check("R1", "reset masks", ev_mask, 0);
        check("R1", "reset cs", start_cs, 0);
        tick();

        // R2 illegal code ignored
        go_sleep(3'd5);
        #1; check("R2", "illegal code stays active", state, 0); tick();

        // R3 halt, interrupt with IF clear
        go_sleep(3'd1);
        intr = 1; if_flag = 0; #1;
        check("R3", "halt intr IF=0 no wake", run_en, 0); tick();
        intr = 1; if_flag = 1; #1;
        check("R3", "halt intr IF=1 wakes", run_en, 1);
        check("R7", "halt wake no monitor reset", mon_rst, 0);
        tick(); idle(); #1;
        check("R6", "active after wake", state, 0); tick();

        // R4 interrupt-tolerant monitor wait
        go_sleep(3'd4);
        lintr = 1; if_flag = 0; #1;
        check("R4", "mwait_if wakes IF=0", run_en, 1);
        check("R7", "mwait_if monitor reset", mon_rst, 1);
        tick(); idle();

        // R5 monitor wait: intr IF=0 no wake, NMI wakes
        go_sleep(3'd3);
        intr = 1; #1; check("R3", "mwait intr IF=0 no wake", run_en, 0); tick();
        nmi = 1; #1; check("R5", "mwait NMI wakes", run_en, 1); tick(); idle();

        // R5/R12 masked NMI ignored, SMI wakes
        mask_set = 3'b001; tick(); idle();
        #1; check("R12", "NMI mask bit0", ev_mask, 1); tick();
        go_sleep(3'd1);
        nmi = 1; #1; check("R5", "masked NMI no wake", run_en, 0); tick();
        smi = 1; #1; check("R5", "SMI wakes", run_en, 1); tick(); idle();

        // R11 masked INIT dropped
        mask_set = 3'b100; tick(); idle();
        init_req = 1; tick(); idle();
        #1; check("R11", "masked INIT not pending", init_pend, 0); tick();

        // R8 wait-for-startup ignores events
        go_sleep(3'd2);
        intr = 1; if_flag = 1; smi = 1; #1;
        check("R8", "wfs ignores intr/SMI", run_en, 0); tick(); idle();
        // R9 startup
        sipi_req = 1; sipi_vec = 8'hA5; #1;
        check("R9", "startup wakes", run_en, 1); tick(); idle(); #1;
        check("R9", "cs after startup", start_cs, 16'hA500);
        check("R9", "masks cleared", ev_mask, 0);
        tick();

        // R10 startup when active ignored
        sipi_req = 1; sipi_vec = 8'hFF; #1;
        check("R10", "ignored flag", sipi_ign, 1); tick(); idle(); #1;
        check("R10", "cs unchanged", start_cs, 16'hA500); tick();

        // R11 INIT latched and wakes from halt
        init_req = 1; tick(); idle(); #1;
        check("R11", "INIT pending", init_pend, 1); tick();
        go_sleep(3'd1);
        #1; check("R5", "pending INIT wakes", run_en, 1); tick(); idle(); #1;
        check("R11", "INIT consumed", init_pend, 0); tick();

        // startup with max vector
        go_sleep(3'd2);
        sipi_req = 1; sipi_vec = 8'hFF; tick(); idle(); #1;
        check("R9", "cs max vector", start_cs, 16'hFF00); tick();

        for (int i = 0; i < 4000; i++) begin
            rst        = ($urandom % 500) == 0;
            sleep_req  = ($urandom % 3) == 0;
            sleep_code = 3'($urandom % 8);
            if_flag    = 1'($urandom % 2);
            intr       = ($urandom % 6) == 0;
            lintr      = ($urandom % 9) == 0;
            nmi        = ($urandom % 11) == 0;
            smi        = ($urandom % 13) == 0;
            init_req   = ($urandom % 10) == 0;
            mask_set   = (($urandom % 16) == 0) ? 3'($urandom % 8) : 3'b000;
            sipi_req   = ($urandom % 7) == 0;
            sipi_vec   = 8'($urandom % 256);
            tick();
        end

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule